// File: doc/BRIEF.md
# Control Endpoint Handshake Controller

This block chooses the reply that one USB control endpoint sends for each token the protocol engine decodes. Software programs a control register that holds a forced-stall flag, the data-sequence bit, separate enables for sending and receiving, and the number of bytes to send. The block also keeps two completion flags, one for sending and one for receiving. Hardware sets a flag when a transfer it granted finishes. Software clears a flag by writing 1 to it. While a flag is set, the endpoint refuses further transfers in that direction.

For each token strobe the block registers a handshake code, the DATA0/DATA1 selection and the byte count for the serial engine, and pulses a valid flag one clock later. A SETUP token is always accepted, and it also releases a forced stall. The data-sequence bit is never toggled by hardware, so software keeps full control of the packet ordering.

Top module: `ep_handshake_ctrl`

## Requirements
- R1: After a synchronous reset, the control image (address 0) reads 0x00, the status image (address 1) reads 0x00, and `hs_valid` is low.
- R2: A token strobe with kind 1 (IN), 2 (OUT) or 3 (SETUP) produces `hs_valid` high for exactly one cycle, one clock after the strobe. A strobe with kind 0 produces no pulse.
- R3: While the stall bit (control bit 7) is set, IN and OUT tokens are answered with code 3 (STALL). This check takes priority over the enable and completion checks.
- R4: With stall clear, an IN token is answered with code 0 (DATA) if the transmit enable (control bit 5) is 1 and the transmit-done flag (status bit 0) is 0. Otherwise it is answered with code 2 (NAK).
- R5: With stall clear, an OUT token is answered with code 1 (ACK) if the receive enable (control bit 4) is 1 and the receive-done flag (status bit 1) is 0. Otherwise it is answered with code 2 (NAK).
- R6: A SETUP token is always answered with code 1 (ACK). It clears the stall bit at the same edge, even when a control write in that cycle sets the stall bit.
- R7: `hs_pid` carries the data-sequence bit (control bit 6) as it stood when the token arrived: 0 selects DATA0 and 1 selects DATA1. Only control writes change that bit.
- R8: `hs_count` carries the 4-bit byte-count field (control bits 3:0) as it stood when the token arrived.
- R9: A `pkt_done` pulse after a DATA grant sets the transmit-done flag. A pulse after an ACK grant (OUT or SETUP) sets the receive-done flag. A pulse after a NAK or STALL reply, or a second pulse, changes nothing.
- R10: Writing address 1 clears each status flag whose data bit is 1 and leaves the others unchanged. When a hardware set and a software clear hit the same flag in the same cycle, the set wins.
- R11: A read strobe loads `reg_rdata` at the next edge with the image selected by `reg_addr`, taken from the values before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Decoded token strobe |
| tok_kind | input | 2 | Token type: 0 none, 1 IN, 2 OUT, 3 SETUP |
| pkt_done | input | 1 | Pulse when the granted data stage finishes |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 control image, 1 status image |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| hs_valid | output | 1 | One-cycle pulse marking a decision |
| hs_code | output | 2 | 0 DATA, 1 ACK, 2 NAK, 3 STALL |
| hs_pid | output | 1 | 0 DATA0, 1 DATA1 |
| hs_count | output | 4 | Bytes to send for a DATA reply |

## Verification
The stall bit and the completion flags are internal state, and an error in them shows up on the very next token of the affected direction. A stall left set by a missed SETUP clear turns every later IN or OUT reply into code 3. A completion flag set with no pending grant turns a valid DATA or ACK reply into a NAK. A flag that never sets lets a second transfer through where a NAK is due. The bench also reads both register images back so that such state is seen even when no token follows. An error in the sequence bit shows on `hs_pid` one cycle after the next token.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;
  localparam int DW    = 8;
  localparam int CNT_W = 4;

  localparam int CTL_STALL = 7;
  localparam int CTL_SEQ   = 6;
  localparam int CTL_TXEN  = 5;
  localparam int CTL_RXEN  = 4;
  localparam int STS_TXD   = 0;
  localparam int STS_RXD   = 1;

  typedef enum logic [1:0] {
    TOK_NONE  = 2'd0,
    TOK_IN    = 2'd1,
    TOK_OUT   = 2'd2,
    TOK_SETUP = 2'd3
  } tok_kind_e;

  typedef enum logic [1:0] {
    HS_DATA  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_code_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_TX   = 2'd1,
    PEND_RX   = 2'd2
  } pend_e;
endpackage

// File: rtl/ep_ctl_regs.sv
module ep_ctl_regs
  import ep_hs_pkg::*;
#(
  parameter int W  = DW,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [W-1:0]  wdata,
  input  logic          setup_clr,
  input  logic          set_tx,
  input  logic          set_rx,
  output logic [W-1:0]  rdata,
  output logic          stall,
  output logic          seq,
  output logic          tx_en,
  output logic          rx_en,
  output logic [CW-1:0] count,
  output logic          tx_done,
  output logic          rx_done
);
  logic [W-1:0] ctl_img, sts_img;
  logic         ctl_wr, sts_wr;

  assign ctl_wr = wr_en && !addr;
  assign sts_wr = wr_en && addr;

  always_comb begin
    ctl_img            = '0;
    ctl_img[CTL_STALL] = stall;
    ctl_img[CTL_SEQ]   = seq;
    ctl_img[CTL_TXEN]  = tx_en;
    ctl_img[CTL_RXEN]  = rx_en;
    ctl_img[CW-1:0]    = count;
    sts_img            = '0;
    sts_img[STS_TXD]   = tx_done;
    sts_img[STS_RXD]   = rx_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stall   <= 1'b0;
      seq     <= 1'b0;
      tx_en   <= 1'b0;
      rx_en   <= 1'b0;
      count   <= '0;
      tx_done <= 1'b0;
      rx_done <= 1'b0;
      rdata   <= '0;
    end else begin
      if (ctl_wr) begin
        stall <= wdata[CTL_STALL];
        seq   <= wdata[CTL_SEQ];
        tx_en <= wdata[CTL_TXEN];
        rx_en <= wdata[CTL_RXEN];
        count <= wdata[CW-1:0];
      end
      // hardware release on SETUP overrides a same-cycle software set
      if (setup_clr) stall <= 1'b0;
      if (sts_wr && wdata[STS_TXD]) tx_done <= 1'b0;
      if (sts_wr && wdata[STS_RXD]) rx_done <= 1'b0;
      // hardware set overrides a same-cycle clear
      if (set_tx) tx_done <= 1'b1;
      if (set_rx) rx_done <= 1'b1;
      if (rd_en) rdata <= addr ? sts_img : ctl_img;
    end
  end

  p_setup_clears_stall_r6: assert property (@(posedge clk) disable iff (rst)
    setup_clr |=> !stall);
  p_seq_only_sw_r7: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr |=> $stable(seq));
  p_tx_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    set_tx |=> tx_done);
  p_rx_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    set_rx |=> rx_done);
endmodule

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
  import ep_hs_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tok_valid,
  input  logic [1:0]    tok_kind,
  input  logic          pkt_done,
  input  logic          stall,
  input  logic          seq,
  input  logic          tx_en,
  input  logic          rx_en,
  input  logic [CW-1:0] count,
  input  logic          tx_done,
  input  logic          rx_done,
  output logic          hs_valid,
  output logic [1:0]    hs_code,
  output logic          hs_pid,
  output logic [CW-1:0] hs_count,
  output logic          setup_clr,
  output logic          set_tx,
  output logic          set_rx
);
  tok_kind_e kind;
  hs_code_e  code_d;
  pend_e     pend, pend_d;
  logic      tok_live;

  assign kind      = tok_kind_e'(tok_kind);
  assign tok_live  = tok_valid && (kind != TOK_NONE);
  assign setup_clr = tok_valid && (kind == TOK_SETUP);
  assign set_tx    = pkt_done && (pend == PEND_TX);
  assign set_rx    = pkt_done && (pend == PEND_RX);

  always_comb begin
    unique case (kind)
      TOK_IN:    code_d = stall ? HS_STALL : ((tx_en && !tx_done) ? HS_DATA : HS_NAK);
      TOK_OUT:   code_d = stall ? HS_STALL : ((rx_en && !rx_done) ? HS_ACK : HS_NAK);
      TOK_SETUP: code_d = HS_ACK;
      default:   code_d = HS_NAK;
    endcase
  end

  always_comb begin
    pend_d = pend;
    if (pkt_done) pend_d = PEND_NONE;
    if (tok_live) begin
      unique case (code_d)
        HS_DATA: pend_d = PEND_TX;
        HS_ACK:  pend_d = PEND_RX;
        default: pend_d = PEND_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_DATA;
      hs_pid   <= 1'b0;
      hs_count <= '0;
      pend     <= PEND_NONE;
    end else begin
      hs_valid <= tok_live;
      pend     <= pend_d;
      if (tok_live) begin
        hs_code  <= code_d;
        hs_pid   <= seq;
        hs_count <= count;
      end
    end
  end

  p_valid_follows_tok_r2: assert property (@(posedge clk) disable iff (rst)
    tok_live |=> hs_valid);
  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (rst)
    !tok_live |=> !hs_valid);
  p_stall_first_r3: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && (kind == TOK_IN || kind == TOK_OUT) && stall) |=> (hs_code == HS_STALL));
  p_in_refused_r4: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && kind == TOK_IN && !stall && (!tx_en || tx_done)) |=> (hs_code == HS_NAK));
  p_setup_ack_r6: assert property (@(posedge clk) disable iff (rst)
    setup_clr |=> (hs_code == HS_ACK));
  p_one_flag_r9: assert property (@(posedge clk) disable iff (rst)
    !(set_tx && set_rx));
endmodule

// File: rtl/ep_handshake_ctrl.sv
module ep_handshake_ctrl
  import ep_hs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tok_valid,
  input  logic [1:0]    tok_kind,
  input  logic          pkt_done,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          hs_valid,
  output logic [1:0]    hs_code,
  output logic          hs_pid,
  output logic [CNT_W-1:0] hs_count
);
  logic stall, seq, tx_en, rx_en, tx_done, rx_done;
  logic setup_clr, set_tx, set_rx;
  logic [CNT_W-1:0] count;

  ep_ctl_regs #(.W(DW), .CW(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .setup_clr(setup_clr), .set_tx(set_tx), .set_rx(set_rx),
    .rdata(reg_rdata), .stall(stall), .seq(seq), .tx_en(tx_en), .rx_en(rx_en),
    .count(count), .tx_done(tx_done), .rx_done(rx_done)
  );

  ep_hs_decide #(.CW(CNT_W)) u_decide (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .pkt_done(pkt_done), .stall(stall), .seq(seq), .tx_en(tx_en), .rx_en(rx_en),
    .count(count), .tx_done(tx_done), .rx_done(rx_done), .hs_valid(hs_valid),
    .hs_code(hs_code), .hs_pid(hs_pid), .hs_count(hs_count),
    .setup_clr(setup_clr), .set_tx(set_tx), .set_rx(set_rx)
  );
endmodule

// File: tb/ep_handshake_ctrl_tb.sv
`timescale 1ns/1ps
module ep_handshake_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic tok_valid, pkt_done, reg_wr, reg_rd, reg_addr;
  logic [1:0] tok_kind;
  logic [7:0] reg_wdata, reg_rdata;
  logic hs_valid, hs_pid;
  logic [1:0] hs_code;
  logic [3:0] hs_count;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ep_handshake_ctrl dut_i (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .pkt_done(pkt_done), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hs_valid(hs_valid),
    .hs_code(hs_code), .hs_pid(hs_pid), .hs_count(hs_count)
  );

  // bench model of the requirements
  logic m_stall, m_seq, m_txen, m_rxen, m_txd, m_rxd;
  logic [3:0] m_cnt;
  int m_pend;

  function automatic logic [1:0] exp_code(input logic [1:0] k);
    if (k == 2'd1) return m_stall ? 2'd3 : ((m_txen && !m_txd) ? 2'd0 : 2'd2);
    if (k == 2'd2) return m_stall ? 2'd3 : ((m_rxen && !m_rxd) ? 2'd1 : 2'd2);
    return 2'd1;
  endfunction

  function automatic string code_req(input logic [1:0] k);
    if (k == 2'd3) return "R6";
    if (m_stall) return "R3";
    return (k == 2'd1) ? "R4" : "R5";
  endfunction

  function automatic logic [7:0] exp_img(input logic a);
    return a ? {6'b0, m_rxd, m_txd} : {m_stall, m_seq, m_txen, m_rxen, m_cnt};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic tv, input logic [1:0] k, input logic pd,
                      input logic wr, input logic rd, input logic a,
                      input logic [7:0] wd, input string rd_req);
    logic ev, epid;
    logic [1:0] ecode;
    logic [3:0] ecnt;
    logic [7:0] erd;
    string creq;
    tok_valid = tv; tok_kind = k; pkt_done = pd;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    ev = tv && (k != 2'd0);
    ecode = exp_code(k); creq = code_req(k);
    epid = m_seq; ecnt = m_cnt; erd = exp_img(a);
    // model update, in the order the requirements fix
    if (pd && m_pend == 1) m_txd = 1'b1;
    if (pd && m_pend == 2) m_rxd = 1'b1;
    if (wr && !a) begin
      m_stall = wd[7]; m_seq = wd[6]; m_txen = wd[5]; m_rxen = wd[4]; m_cnt = wd[3:0];
    end
    if (tv && k == 2'd3) m_stall = 1'b0;
    if (wr && a) begin
      if (wd[0] && !(pd && m_pend == 1)) m_txd = 1'b0;
      if (wd[1] && !(pd && m_pend == 2)) m_rxd = 1'b0;
    end
    if (ev) m_pend = (ecode == 2'd0) ? 1 : ((ecode == 2'd1) ? 2 : 0);
    else if (pd) m_pend = 0;
    @(posedge clk);
    @(negedge clk);
    check(hs_valid == ev, "R2", hs_valid, ev);
    if (ev) begin
      check(hs_code == ecode, creq, hs_code, ecode);
      check(hs_pid == epid, "R7", hs_pid, epid);
      check(hs_count == ecnt, "R8", hs_count, ecnt);
    end
    if (rd) check(reg_rdata == erd, rd_req, reg_rdata, erd);
  endtask

  task automatic idle();
    step(0, 2'd0, 0, 0, 0, 0, 8'h00, "");
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'h0005_eed1);
    {tok_valid, pkt_done, reg_wr, reg_rd, reg_addr} = '0;
    tok_kind = 2'd0; reg_wdata = 8'h00;
    rst = 1'b1;
    m_stall = 0; m_seq = 0; m_txen = 0; m_rxen = 0; m_txd = 0; m_rxd = 0;
    m_cnt = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset images
    step(0, 2'd0, 0, 0, 1, 0, 8'h00, "R1");
    step(0, 2'd0, 0, 0, 1, 1, 8'h00, "R1");
    // R6: SETUP clear beats a same-cycle stall write
    step(0, 2'd0, 0, 1, 0, 0, 8'h80, "");
    step(1, 2'd1, 0, 0, 0, 0, 8'h00, "");            // R3 STALL
    step(1, 2'd3, 0, 1, 0, 0, 8'hF3, "");            // SETUP + write with stall
    step(0, 2'd0, 0, 0, 1, 0, 8'h00, "R6");          // stall must read 0
    step(1, 2'd0, 0, 0, 0, 0, 8'h00, "");            // R2 reserved kind
    // R9: pkt_done after SETUP ACK sets rx_done; then OUT gets NAK
    step(0, 2'd0, 1, 0, 1, 1, 8'h00, "R9");
    step(0, 2'd0, 0, 0, 1, 1, 8'h00, "R9");
    step(1, 2'd2, 0, 0, 0, 0, 8'h00, "");            // R5 NAK, rx_done set
    // R10: write 0 keeps, write 1 clears
    step(0, 2'd0, 0, 1, 0, 1, 8'h00, "");
    step(0, 2'd0, 0, 0, 1, 1, 8'h00, "R10");
    step(0, 2'd0, 0, 1, 0, 1, 8'h02, "");
    step(0, 2'd0, 0, 0, 1, 1, 8'h00, "R10");
    // R9: IN DATA then pkt_done sets tx_done; next IN is NAK
    step(1, 2'd1, 0, 0, 0, 0, 8'h00, "");
    step(0, 2'd0, 1, 0, 0, 0, 8'h00, "");
    step(0, 2'd0, 0, 0, 1, 1, 8'h00, "R9");
    step(1, 2'd1, 0, 0, 0, 0, 8'h00, "");            // R4 NAK
    step(0, 2'd0, 1, 0, 0, 0, 8'h00, "");            // no pending grant
    step(0, 2'd0, 0, 1, 0, 1, 8'h01, "");
    step(0, 2'd0, 0, 0, 1, 1, 8'h00, "R9");
    // R10: set and clear in the same cycle, set wins
    step(1, 2'd2, 0, 0, 0, 0, 8'h00, "");            // OUT ACK
    step(0, 2'd0, 1, 1, 0, 1, 8'h03, "");
    step(0, 2'd0, 0, 0, 1, 1, 8'h00, "R10");
    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic tv, pd, wr, rd, a;
      logic [1:0] k;
      logic [7:0] wd;
      tv = ($urandom % 3) == 0;
      k  = 2'($urandom % 4);
      pd = ($urandom % 4) == 0;
      wr = ($urandom % 6) == 0;
      rd = ($urandom % 3) == 0;
      a  = 1'($urandom % 2);
      wd = 8'($urandom);
      if (wd[7] && ($urandom % 3) != 0) wd[7] = 1'b0;
      step(tv, k, pd, wr, rd, a, wd, "R11");
    end
    idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule